// File: doc/BRIEF.md
# Complex CNN Euler Integration Core

This block advances the state of a complex-valued cellular neural network by one forward-Euler timestep on each run. The state array is held in two internal frame memories that alternate: one holds the present frame and is only read, the other receives the updated frame and is only written. The roles of the two frames swap when a timestep finishes. For each pixel, in row-major order, the core reads five state values: the pixel itself and its west, east, north and south neighbours. It issues one complex template multiply per clock, so each pixel takes five clocks. It then adds a control term (a complex gain times the 8-bit input pixel), scales the sum by one quarter with an arithmetic shift, and adds the present state. Because the decay term is folded into the centre coefficient, the next state is x + ((Σ A·x + β·u) >>> 2).

A controller writes the six complex coefficients while the core is idle. It supplies the input image through a one-cycle-latency read port and pulses `start` to launch a timestep. Every state value written to the next frame also appears on the output stream, so a downstream consumer sees each new frame as it is produced. `done` pulses once when the step completes.

Sequencer states and transitions:
- IDLE→ISSUE on `start`.
- ISSUE→DRAIN after the last tap of the last pixel.
- DRAIN→DONE when the last pixel's write leaves the pipeline.
- DONE→IDLE after one cycle. This is where the frames swap.

Top module: `cnn_euler_core`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `out_valid` and `pix_rd` are 0.
- R2: State values are complex, with a 16-bit real and a 16-bit imaginary part, each signed two's complement Q4.12. `out_re` and `out_im` carry the two parts.
- R3: Coefficient writes use `tpl_data` = {imag[31:16], real[15:0]}. The `tpl_sel` codes are 0 centre, 1 west (column−1), 2 east (column+1), 3 north (row−1), 4 south (row+1) and 5 control gain β. A neighbour outside the array reads as zero.
- R4: Each complex product is re = (ar·xr − ai·xi) >>> 12 and im = (ar·xi + ai·xr) >>> 12, each saturated to 16 bits. The products are summed with saturating adds in tap order centre, west, east, north, south. The control term per part is sat((β·u) >>> 8), with u the unsigned 8-bit pixel. Then s = sat(sum + control), d = s >>> 2, and next = sat(x + d).
- R5: When `first` is 1 at start, the present state is taken as all zero, both for the neighbour reads and for the x term.
- R6: The frame written by one step is the present frame of the next step.
- R7: If `start` is sampled in cycle s, the state of pixel k (index row·COLS+col) is written, with `out_valid`=1 and `out_addr`=k, in cycle s+18+5k. This is a 17-cycle read-to-write latency at one tap per clock. `done` is high only in cycle s+5·N+14, where N is the number of pixels. `busy` is high from s+1 through that cycle.
- R8: Coefficient writes while `busy` is 1 have no effect. Writes while idle take effect for the next step.
- R9: `start` while `busy` is 1 is ignored. Each step gives exactly N writes and one `done`.
- R10: The input pixel of pixel k is read with `pix_rd`=1 and `pix_addr`=k in cycle s+1+5k. `pix_data` must be valid in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tpl_we | input | 1 | Coefficient write strobe |
| tpl_sel | input | 3 | Coefficient select |
| tpl_data | input | 32 | Coefficient {imag, real} |
| pix_rd | output | 1 | Input pixel read enable |
| pix_addr | output | $clog2(ROWS*COLS) | Input pixel address |
| pix_data | input | 8 | Input pixel, one cycle after read |
| start | input | 1 | Launch one timestep |
| first | input | 1 | Treat present state as zero |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle completion pulse |
| out_valid | output | 1 | Next-state write strobe |
| out_addr | output | $clog2(ROWS*COLS) | Pixel index written |
| out_re | output | 16 | Next-state real part |
| out_im | output | 16 | Next-state imaginary part |

## Verification
The assertions assume the following about the inputs:
- `start` is raised only as a pulse.
- Coefficient writes may come at any time, because a frozen coefficient bank is what they check.
- The pixel source answers exactly one cycle after `pix_rd` and holds its image constant for the whole step.

The stimulus keeps within these assumptions. It never changes the pixel image during a run. It issues mid-step coefficient writes and repeated starts deliberately, since these must be ignored. Random coefficients are drawn mostly from the range where saturation is rare, and a directed all-maximum case forces saturation at every stage.

// File: rtl/cnn_euler_pkg.sv
package cnn_euler_pkg;

    localparam int QW       = 16;
    localparam int FRAC     = 12;
    localparam int NTAPS    = 5;
    localparam int NCOEF    = NTAPS + 1;
    localparam int PIPE_LAT = 17;

    typedef logic signed [QW-1:0] q_t;

    typedef struct packed {
        q_t im;
        q_t re;
    } cq_t;

    function automatic q_t sat_q(input logic signed [39:0] v);
        if (v > 40'sd32767)
            return 16'sh7fff;
        else if (v < -40'sd32768)
            return 16'sh8000;
        else
            return v[15:0];
    endfunction

endpackage

// File: rtl/cnn_delay.sv
module cnn_delay #(
    parameter int W = 8,
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (N == 0) begin : g_wire
            assign q = d;
        end else begin : g_sr
            logic [W-1:0] sr [N];
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < N; i++) sr[i] <= '0;
                end else begin
                    sr[0] <= d;
                    for (int i = 1; i < N; i++) sr[i] <= sr[i-1];
                end
            end
            assign q = sr[N-1];
        end
    endgenerate
endmodule

// File: rtl/cnn_state_bank.sv
module cnn_state_bank #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        if (rd_en) rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/cnn_cmul.sv
module cnn_cmul
    import cnn_euler_pkg::*;
(
    input  logic clk,
    input  cq_t  a,
    input  cq_t  x,
    output cq_t  p
);
    logic signed [31:0] m_rr, m_ii, m_ri, m_ir;
    logic signed [32:0] s_re, s_im;

    always_ff @(posedge clk) begin
        m_rr <= a.re * x.re;
        m_ii <= a.im * x.im;
        m_ri <= a.re * x.im;
        m_ir <= a.im * x.re;
        s_re <= 33'(m_rr) - 33'(m_ii);
        s_im <= 33'(m_ri) + 33'(m_ir);
        p.re <= sat_q(40'(s_re >>> FRAC));
        p.im <= sat_q(40'(s_im >>> FRAC));
    end
endmodule

// File: rtl/cnn_issue_seq.sv
module cnn_issue_seq #(
    parameter int ROWS = 32,
    parameter int COLS = 32,
    parameter int AW   = $clog2(ROWS*COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          first,
    input  logic          wr_last,
    output logic          busy,
    output logic          done,
    output logic          iss_valid,
    output logic [2:0]    iss_tap,
    output logic          iss_zero,
    output logic [AW-1:0] iss_raddr,
    output logic [AW-1:0] iss_pix,
    output logic          iss_last,
    output logic          pix_rd
);
    localparam int RW = $clog2(ROWS);
    localparam int CW = $clog2(COLS);
    localparam logic [RW-1:0] ROW_END = RW'(ROWS - 1);
    localparam logic [CW-1:0] COL_END = CW'(COLS - 1);
    localparam logic [2:0]    TAP_END = 3'd4;

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_DRAIN, S_DONE} st_t;

    st_t           state, nxt;
    logic [RW-1:0] row, nr;
    logic [CW-1:0] col, nc;
    logic [2:0]    tap;
    logic          first_q, outside;
    logic          frame_end;

    assign frame_end = (tap == TAP_END) && (row == ROW_END) && (col == COL_END);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start)     nxt = S_ISSUE;
            S_ISSUE: if (frame_end) nxt = S_DRAIN;
            S_DRAIN: if (wr_last)   nxt = S_DONE;
            S_DONE:                 nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0; col <= '0; tap <= '0; first_q <= 1'b0;
        end else if (state == S_IDLE) begin
            row <= '0; col <= '0; tap <= '0;
            if (start) first_q <= first;
        end else if (state == S_ISSUE) begin
            if (tap == TAP_END) begin
                tap <= '0;
                if (col == COL_END) begin
                    col <= '0;
                    row <= row + 1'b1;
                end else begin
                    col <= col + 1'b1;
                end
            end else begin
                tap <= tap + 1'b1;
            end
        end
    end

    always_comb begin
        nr = row; nc = col; outside = 1'b0;
        unique case (tap)
            3'd1: begin nc = col - 1'b1; outside = (col == '0);     end
            3'd2: begin nc = col + 1'b1; outside = (col == COL_END); end
            3'd3: begin nr = row - 1'b1; outside = (row == '0);     end
            3'd4: begin nr = row + 1'b1; outside = (row == ROW_END); end
            default: ;
        endcase
        if (outside) begin nr = row; nc = col; end
    end

    always_comb begin
        busy      = (state != S_IDLE);
        done      = (state == S_DONE);
        iss_valid = (state == S_ISSUE);
        iss_tap   = tap;
        iss_zero  = outside | first_q;
        iss_raddr = AW'(nr) * AW'(COLS) + AW'(nc);
        iss_pix   = AW'(row) * AW'(COLS) + AW'(col);
        iss_last  = iss_valid && frame_end;
        pix_rd    = iss_valid && (tap == 3'd0);
    end

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_start_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    a_r10_pix_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        pix_rd |=> !pix_rd);
endmodule

// File: rtl/cnn_euler_core.sv
module cnn_euler_core
    import cnn_euler_pkg::*;
#(
    parameter int ROWS = 32,
    parameter int COLS = 32,
    localparam int NPIX = ROWS * COLS,
    localparam int AW   = $clog2(NPIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tpl_we,
    input  logic [2:0]    tpl_sel,
    input  logic [31:0]   tpl_data,
    output logic          pix_rd,
    output logic [AW-1:0] pix_addr,
    input  logic [7:0]    pix_data,
    input  logic          start,
    input  logic          first,
    output logic          busy,
    output logic          done,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output logic [15:0]   out_re,
    output logic [15:0]   out_im
);
    localparam int BASE_LAT = 13;
    localparam int PAD      = PIPE_LAT - BASE_LAT;
    localparam int SBW      = 4 + AW;

    cq_t [NCOEF-1:0] tpl;
    logic            cur_bank;

    logic          iss_valid, iss_zero, iss_last, wr_last;
    logic [2:0]    iss_tap;
    logic [AW-1:0] iss_raddr, iss_pix;

    cnn_issue_seq #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .first(first), .wr_last(wr_last),
        .busy(busy), .done(done), .iss_valid(iss_valid), .iss_tap(iss_tap),
        .iss_zero(iss_zero), .iss_raddr(iss_raddr), .iss_pix(iss_pix),
        .iss_last(iss_last), .pix_rd(pix_rd)
    );
    assign pix_addr = iss_pix;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpl      <= '0;
            cur_bank <= 1'b0;
        end else begin
            if (tpl_we && !busy && (tpl_sel < 3'(NCOEF))) tpl[tpl_sel] <= tpl_data;
            if (done) cur_bank <= ~cur_bank;
        end
    end

    // ping-pong frames
    logic [31:0]   rd_b [2];
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    cq_t           wr_val;

    generate
        for (genvar b = 0; b < 2; b++) begin : g_bank
            cnn_state_bank #(.DEPTH(NPIX), .AW(AW)) u_bank (
                .clk(clk),
                .rd_en(iss_valid && (cur_bank == 1'(b))),
                .rd_addr(iss_raddr),
                .rd_data(rd_b[b]),
                .wr_en(wr_valid && (cur_bank != 1'(b))),
                .wr_addr(wr_addr),
                .wr_data(wr_val)
            );
        end
    endgenerate

    // stage +1: masked state read
    logic       z1;
    logic [2:0] tap1;
    cq_t        x1;
    always_ff @(posedge clk) begin
        if (!rst_n) begin z1 <= 1'b1; tap1 <= '0; end
        else        begin z1 <= iss_zero; tap1 <= iss_tap; end
    end
    assign x1 = z1 ? '0 : cq_t'(rd_b[cur_bank]);

    // stages +2..+4: template multiply
    cq_t prod;
    cnn_cmul u_mul (.clk(clk), .a(tpl[tap1]), .x(x1), .p(prod));

    // sideband aligned with the latched product (+5)
    logic [SBW-1:0] sb_in, sb5;
    assign sb_in = {iss_valid, iss_tap == 3'd0, iss_tap == 3'd4, iss_last, iss_pix};
    cnn_delay #(.W(SBW), .N(5)) u_sb (.clk(clk), .rst_n(rst_n), .d(sb_in), .q(sb5));

    cq_t prod_l;
    always_ff @(posedge clk) prod_l <= prod;

    // stage +6: accumulate five taps
    cq_t           acc;
    logic          accv, acc_last;
    logic [AW-1:0] acc_pix;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accv <= 1'b0; acc_last <= 1'b0; acc_pix <= '0; acc <= '0;
        end else begin
            accv     <= sb5[SBW-1] & sb5[SBW-3];
            acc_last <= sb5[SBW-4];
            acc_pix  <= sb5[AW-1:0];
            if (sb5[SBW-1]) begin
                if (sb5[SBW-2]) acc <= prod_l;
                else begin
                    acc.re <= sat_q(40'(acc.re) + 40'(prod_l.re));
                    acc.im <= sat_q(40'(acc.im) + 40'(prod_l.im));
                end
            end
        end
    end

    // alignment delay lines for input pixel and present state
    logic [7:0] u_al;
    cq_t        xc;
    cnn_delay #(.W(8),  .N(9))  u_udl (.clk(clk), .rst_n(rst_n), .d(pix_data), .q(u_al));
    cnn_delay #(.W(32), .N(11)) u_xdl (.clk(clk), .rst_n(rst_n), .d(x1),       .q(xc));

    // add control term, shift, add state
    logic signed [24:0] bu_re, bu_im;
    assign bu_re = tpl[NTAPS].re * $signed({1'b0, u_al});
    assign bu_im = tpl[NTAPS].im * $signed({1'b0, u_al});

    cq_t           s2, d3, n4;
    logic          v2, v3, v4, l2, l3, l4;
    logic [AW-1:0] p2, p3, p4;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2 <= 1'b0; v3 <= 1'b0; v4 <= 1'b0;
            l2 <= 1'b0; l3 <= 1'b0; l4 <= 1'b0;
            p2 <= '0; p3 <= '0; p4 <= '0;
            s2 <= '0; d3 <= '0; n4 <= '0;
        end else begin
            v2 <= accv; l2 <= acc_last; p2 <= acc_pix;
            s2.re <= sat_q(40'(acc.re) + 40'(sat_q(40'(bu_re >>> 8))));
            s2.im <= sat_q(40'(acc.im) + 40'(sat_q(40'(bu_im >>> 8))));
            v3 <= v2; l3 <= l2; p3 <= p2;
            d3.re <= s2.re >>> 2;
            d3.im <= s2.im >>> 2;
            v4 <= v3; l4 <= l3; p4 <= p3;
            n4.re <= sat_q(40'(xc.re) + 40'(d3.re));
            n4.im <= sat_q(40'(xc.im) + 40'(d3.im));
        end
    end

    // output padding to the fixed latency
    logic [SBW+29:0] pad_in, pad_out;
    assign pad_in = {v4, l4, p4, n4};
    cnn_delay #(.W(SBW+30), .N(PAD)) u_pad (.clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_out));

    logic wr_l;
    assign {wr_valid, wr_l, wr_addr, wr_val} = pad_out;
    assign wr_last   = wr_valid & wr_l;
    assign out_valid = wr_valid;
    assign out_addr  = wr_addr;
    assign out_re    = wr_val.re;
    assign out_im    = wr_val.im;

    a_r8_tpl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(tpl));
    a_r7_write_in_step: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);
endmodule

// File: tb/cnn_euler_core_tb_top.sv
module cnn_euler_core_tb_top;
    localparam int ROWS = 8, COLS = 8, N = ROWS * COLS, AW = $clog2(N);

    logic clk = 0, rst_n = 0;
    logic tpl_we = 0, start = 0, first = 0;
    logic [2:0] tpl_sel = 0;
    logic [31:0] tpl_data = 0;
    logic pix_rd, busy, done, out_valid;
    logic [AW-1:0] pix_addr, out_addr;
    logic [7:0] pix_q = 0;
    logic [15:0] out_re, out_im;

    always #2 clk = ~clk;

    cnn_euler_core #(.ROWS(ROWS), .COLS(COLS)) dut_i (
        .clk(clk), .rst_n(rst_n), .tpl_we(tpl_we), .tpl_sel(tpl_sel), .tpl_data(tpl_data),
        .pix_rd(pix_rd), .pix_addr(pix_addr), .pix_data(pix_q), .start(start), .first(first),
        .busy(busy), .done(done), .out_valid(out_valid), .out_addr(out_addr),
        .out_re(out_re), .out_im(out_im));

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [7:0] pixmem [N];
    always @(posedge clk) if (pix_rd) pix_q <= pixmem[pix_addr];

    int nchk = 0, nfail = 0;
    int got_re [N], got_im [N], got_cyc [N];
    int wcnt, done_cnt, done_cyc, rd_cnt, rd_bad, s_cyc;
    int cur_re [N], cur_im [N], exp_re [N], exp_im [N];
    int t_re [6], t_im [6];

    always @(negedge clk) begin
        if (out_valid) begin
            got_re[out_addr]  = int'($signed(out_re));
            got_im[out_addr]  = int'($signed(out_im));
            got_cyc[out_addr] = cyc;
            wcnt++;
        end
        if (done) begin done_cnt++; done_cyc = cyc; end
        if (pix_rd) begin
            rd_cnt++;
            if (((cyc - s_cyc - 1) % 5 != 0) || (int'(pix_addr) != (cyc - s_cyc - 1) / 5)) rd_bad++;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int sat(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    task automatic model_step(input bit first_i);
        for (int p = 0; p < N; p++) begin
            int r = p / COLS, c = p % COLS;
            int acr = 0, aci = 0;
            for (int t = 0; t < 5; t++) begin
                int nr = r, nc = c, xr = 0, xi = 0, pr, pi;
                bit ok = 1;
                case (t)
                    1: begin nc = c - 1; ok = (c > 0); end
                    2: begin nc = c + 1; ok = (c < COLS - 1); end
                    3: begin nr = r - 1; ok = (r > 0); end
                    4: begin nr = r + 1; ok = (r < ROWS - 1); end
                    default: ;
                endcase
                if (ok && !first_i) begin xr = cur_re[nr*COLS+nc]; xi = cur_im[nr*COLS+nc]; end
                pr = sat((longint'(t_re[t]) * xr - longint'(t_im[t]) * xi) >>> 12);
                pi = sat((longint'(t_re[t]) * xi + longint'(t_im[t]) * xr) >>> 12);
                if (t == 0) begin acr = pr; aci = pi; end
                else begin acr = sat(longint'(acr) + pr); aci = sat(longint'(aci) + pi); end
            end
            begin
                int u = int'(pixmem[p]);
                int sr = sat(longint'(acr) + sat((longint'(t_re[5]) * u) >>> 8));
                int si = sat(longint'(aci) + sat((longint'(t_im[5]) * u) >>> 8));
                int xr0 = first_i ? 0 : cur_re[p], xi0 = first_i ? 0 : cur_im[p];
                exp_re[p] = sat(longint'(xr0) + (sr >>> 2));
                exp_im[p] = sat(longint'(xi0) + (si >>> 2));
            end
        end
    endtask

    task automatic write_tpl(input int sel, input int re, input int im);
        @(negedge clk);
        tpl_we = 1; tpl_sel = 3'(sel); tpl_data = {16'(im), 16'(re)};
        @(negedge clk);
        tpl_we = 0;
        t_re[sel] = re; t_im[sel] = im;
    endtask

    task automatic run_step(input bit first_i, input bit poke, input bit dbl, input string tag);
        int guard = 0, badc = 0, badv = 0;
        wcnt = 0; done_cnt = 0; rd_cnt = 0; rd_bad = 0; done_cyc = -1;
        @(negedge clk);
        s_cyc = cyc; start = 1; first = first_i;
        @(negedge clk);
        start = 0;
        repeat (20) @(negedge clk);
        if (dbl) begin start = 1; @(negedge clk); start = 0; end
        if (poke) begin
            tpl_we = 1; tpl_sel = 3'd0; tpl_data = 32'h7fff_7fff;
            @(negedge clk); tpl_sel = 3'd5; @(negedge clk); tpl_we = 0;
        end
        while (done_cnt == 0 && guard < 5000) begin @(negedge clk); guard++; end
        repeat (30) @(negedge clk);
        check(!busy, {tag, " R7 busy clear"}, busy, 0);
        model_step(first_i);
        for (int p = 0; p < N; p++) begin
            if (got_re[p] != exp_re[p] || got_im[p] != exp_im[p]) begin
                badv++;
                if (badv < 4) check(0, {tag, " R4 value"}, got_re[p] * 65536 + got_im[p],
                                    exp_re[p] * 65536 + exp_im[p]);
            end
            if (got_cyc[p] != s_cyc + 18 + 5 * p) badc++;
        end
        check(badv == 0, {tag, " R4 R2 frame mismatches"}, badv, 0);
        check(badc == 0, {tag, " R7 write timing"}, badc, 0);
        check(wcnt == N, {tag, " R9 write count"}, wcnt, N);
        check(done_cnt == 1, {tag, " R9 done count"}, done_cnt, 1);
        check(done_cyc == s_cyc + 5 * N + 14, {tag, " R7 done cycle"}, done_cyc - s_cyc, 5 * N + 14);
        check(rd_cnt == N && rd_bad == 0, {tag, " R10 pixel reads"}, rd_bad, 0);
        for (int p = 0; p < N; p++) begin cur_re[p] = exp_re[p]; cur_im[p] = exp_im[p]; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 6; i++) begin t_re[i] = 0; t_im[i] = 0; end
        repeat (3) @(negedge clk);
        check(!busy && !done && !out_valid && !pix_rd, "R1 in reset", {busy, done, out_valid, pix_rd}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check(!busy && !done && !out_valid && !pix_rd, "R1 after reset", {busy, done, out_valid, pix_rd}, 0);

        // directed impulse: beta = 1.0, small cross
        for (int p = 0; p < N; p++) pixmem[p] = 0;
        pixmem[2*COLS+3] = 8'd255;
        write_tpl(0, -4096, 0);
        write_tpl(1, 1024, 512);
        write_tpl(2, 1024, -512);
        write_tpl(3, 1024, 256);
        write_tpl(4, 1024, -256);
        write_tpl(5, 4096, 0);
        run_step(1, 0, 0, "impulse R5");
        check(got_re[2*COLS+3] == 1020, "R4 impulse centre", got_re[2*COLS+3], 1020);
        check(got_re[0] == 0, "R5 zero elsewhere", got_re[0], 0);
        run_step(0, 0, 0, "spread R6 R3");
        check(got_re[2*COLS+2] != 0, "R3 west neighbour reached", got_re[2*COLS+2], 1);

        // random templates and pixels
        for (int k = 0; k < 3; k++) begin
            for (int p = 0; p < N; p++) pixmem[p] = 8'($urandom_range(0, 255));
            for (int i = 0; i < 6; i++)
                write_tpl(i, int'($urandom_range(0, 16383)) - 8192, int'($urandom_range(0, 16383)) - 8192);
            run_step(k == 0, 0, 0, "random R8 idle write");
        end
        run_step(0, 1, 0, "poke R8 busy write");
        run_step(0, 0, 1, "restart R9");
        run_step(0, 0, 0, "after poke R8");

        // directed saturation
        for (int p = 0; p < N; p++) pixmem[p] = 8'd255;
        for (int i = 0; i < 6; i++) write_tpl(i, 32767, 32767);
        run_step(0, 0, 0, "saturate R4");
        run_step(0, 0, 0, "saturate2 R4");
        for (int i = 0; i < 6; i++) write_tpl(i, -32768, 32767);
        run_step(0, 0, 0, "saturate3 R4");

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule